// File: doc/BRIEF.md
# Gated Event Timer with Toggle and One-Shot Window

This block is a free-running up-counter that only advances while a gate condition holds. The gate comes either from an external pin, which is brought into the clock domain through a synchronizer, or from the one-cycle wrap pulse of a neighbouring timer. The gate can be inverted, so either level can enable counting. With the gate turned off, the counter advances on every cycle while the timer is switched on.

Two measurement aids sit on the gate path. In toggle mode, every rising edge of the (already inverted, if selected) gate flips a flip-flop, and that flip-flop acts as the gate. The counter then runs from one gate edge to the next, which measures a full gate period instead of one level. Turning off toggle mode or the timer forces the flip-flop low and holds it low. This makes the first edge after re-enabling always the one that starts counting. In one-shot mode, an arm pulse lets the counter run for exactly one gate window. When that window closes, the block reports completion and disarms. One-shot mode can be combined with toggle mode to capture exactly one full period.

Top module: `gated_timer`

## Requirements
- R1: After reset, count_o is 0 and wrap_o, window_done_o, gate_val_o and pulse_busy_o are all 0.
- R2: The count rises by exactly one per cycle in which tmr_on_i is 1 and the gate is active. With gate_en_i at 0, the count rises on every cycle in which tmr_on_i is 1. With tmr_on_i at 0, the count holds its value.
- R3: gate_pin_i passes through two synchronizer stages. If the pin is held active for N cycles, the count rises by exactly N.
- R4: With gate_inv_i at 1, the gate is active while its source is 0 and inactive while it is 1.
- R5: With gate_src_i at 1, the gate source is peer_wrap_i, sampled without a synchronizer. With gate_src_i at 0, the source is gate_pin_i.
- R6: With toggle_en_i at 1, a flip-flop toggles on each rising edge of the polarity-adjusted source and acts as the gate. Two source rising edges P cycles apart add exactly P to the count.
- R7: While toggle_en_i is 0, the toggle flip-flop is held at 0. After toggle_en_i returns to 1, gate_val_o is 0 until the next source rising edge, and the count holds during that time.
- R8: While tmr_on_i is 0, the toggle flip-flop is held at 0. After tmr_on_i returns to 1, gate_val_o is 0 until the next source rising edge, and the count holds during that time.
- R9: With pulse_mode_i at 1, a pulse_arm_i pulse sets pulse_busy_o. The next rising edge of the gate opens a window in which the count advances while the gate is active. When the gate falls, the window closes, pulse_busy_o clears and window_done_o pulses for one cycle. Later gate windows do not advance the count until the block is armed again.
- R10: One-shot mode combined with toggle mode counts exactly one full source period after arming.
- R11: The count wraps from 0xFFFF to 0x0000, and wrap_o is 1 for exactly the one cycle that follows that wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_on_i | input | 1 | Timer on; clears the toggle flip-flop when low |
| gate_en_i | input | 1 | 1: count only while the gate is active; 0: ignore the gate |
| gate_src_i | input | 1 | Gate source select: 0 pin, 1 peer wrap pulse |
| gate_pin_i | input | 1 | Asynchronous external gate pin |
| peer_wrap_i | input | 1 | Wrap pulse from another timer (same clock) |
| gate_inv_i | input | 1 | 1 inverts the gate source |
| toggle_en_i | input | 1 | Toggle mode enable |
| pulse_mode_i | input | 1 | One-shot window mode enable |
| pulse_arm_i | input | 1 | One-cycle arm request for one-shot mode |
| count_o | output | 16 | Counter value |
| wrap_o | output | 1 | One-cycle pulse after a 0xFFFF to 0 wrap |
| window_done_o | output | 1 | One-cycle pulse when a one-shot window closes |
| gate_val_o | output | 1 | Current gate after polarity and toggle stages |
| pulse_busy_o | output | 1 | One-shot armed or window open |

## Verification
Several properties are checked on every cycle. The count only ever moves by +1, and it stays put while the timer is off. A wrap pulse always sees a zero count, and completion never coincides with busy. Switching off either the timer or toggle mode always leaves the toggle gate low one cycle later. Exact window lengths can only be shown by the bench's scenarios. These include the two-stage pin latency, the full-period totals from both gate sources, the one-shot window that ignores later gate activity, and the single wrap after 65536 cycles.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;

    localparam int CNT_W = 16;

    typedef enum logic [1:0] {
        SHOT_IDLE   = 2'd0,
        SHOT_ARMED  = 2'd1,
        SHOT_WINDOW = 2'd2
    } shot_state_t;

    typedef struct packed {
        logic src_sel;
        logic invert;
        logic toggle;
    } gate_cfg_t;

    function automatic logic rise_of(input logic now, input logic prev);
        return now & ~prev;
    endfunction

endpackage

// File: rtl/gtmr_gate_cond.sv
module gtmr_gate_cond
    import gtmr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      run,
    input  gate_cfg_t cfg,
    input  logic      pin,
    input  logic      peer,
    output logic      gate
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic src, pol, pol_q, flip_q;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
    end

    assign src = cfg.src_sel ? peer : sync_q[SYNC_STAGES-1];
    assign pol = src ^ cfg.invert;

    always_ff @(posedge clk) begin
        if (rst) begin
            pol_q  <= 1'b0;
            flip_q <= 1'b0;
        end else begin
            pol_q <= pol;
            if (!cfg.toggle || !run)
                flip_q <= 1'b0;
            else if (rise_of(pol, pol_q))
                flip_q <= ~flip_q;
        end
    end

    assign gate = cfg.toggle ? flip_q : pol;
endmodule

// File: rtl/gtmr_shot_ctl.sv
module gtmr_shot_ctl
    import gtmr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic mode,
    input  logic arm,
    input  logic gate,
    output logic eff_gate,
    output logic busy,
    output logic done
);
    shot_state_t state_q, state_d;
    logic gate_q, gate_rise;

    assign gate_rise = rise_of(gate, gate_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SHOT_IDLE:   if (arm) state_d = SHOT_ARMED;
            SHOT_ARMED:  if (gate_rise) state_d = SHOT_WINDOW;
            SHOT_WINDOW: if (!gate) state_d = SHOT_IDLE;
            default:     state_d = SHOT_IDLE;
        endcase
        if (!mode || !run) state_d = SHOT_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SHOT_IDLE;
            gate_q  <= 1'b0;
            done    <= 1'b0;
        end else begin
            state_q <= state_d;
            gate_q  <= gate;
            done    <= mode && run && (state_q == SHOT_WINDOW) && !gate;
        end
    end

    always_comb begin
        if (mode)
            eff_gate = ((state_q == SHOT_ARMED) && gate_rise) ||
                       ((state_q == SHOT_WINDOW) && gate);
        else
            eff_gate = gate;
    end

    assign busy = (state_q != SHOT_IDLE);
endmodule

// File: rtl/gtmr_counter.sv
module gtmr_counter #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    output logic [WIDTH-1:0] value,
    output logic             wrapped
);
    localparam logic [WIDTH-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            value   <= '0;
            wrapped <= 1'b0;
        end else begin
            wrapped <= step && (value == TOP);
            if (step) value <= value + 1'b1;
        end
    end
endmodule

// File: rtl/gated_timer.sv
module gated_timer
    import gtmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tmr_on_i,
    input  logic             gate_en_i,
    input  logic             gate_src_i,
    input  logic             gate_pin_i,
    input  logic             peer_wrap_i,
    input  logic             gate_inv_i,
    input  logic             toggle_en_i,
    input  logic             pulse_mode_i,
    input  logic             pulse_arm_i,
    output logic [CNT_W-1:0] count_o,
    output logic             wrap_o,
    output logic             window_done_o,
    output logic             gate_val_o,
    output logic             pulse_busy_o
);
    gate_cfg_t cfg;
    logic      cond_gate, shot_gate, step;

    assign cfg = '{src_sel: gate_src_i, invert: gate_inv_i, toggle: toggle_en_i};

    gtmr_gate_cond #(.SYNC_STAGES(2)) u_cond (
        .clk  (clk),
        .rst  (rst),
        .run  (tmr_on_i),
        .cfg  (cfg),
        .pin  (gate_pin_i),
        .peer (peer_wrap_i),
        .gate (cond_gate)
    );

    gtmr_shot_ctl u_shot (
        .clk      (clk),
        .rst      (rst),
        .run      (tmr_on_i),
        .mode     (pulse_mode_i),
        .arm      (pulse_arm_i),
        .gate     (cond_gate),
        .eff_gate (shot_gate),
        .busy     (pulse_busy_o),
        .done     (window_done_o)
    );

    assign step = tmr_on_i && (gate_en_i ? shot_gate : 1'b1);

    gtmr_counter #(.WIDTH(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .step    (step),
        .value   (count_o),
        .wrapped (wrap_o)
    );

    assign gate_val_o = cond_gate;
endmodule

// File: rtl/gated_timer_chk.sv
module gated_timer_chk
    import gtmr_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             tmr_on_i,
    input logic             toggle_en_i,
    input logic [CNT_W-1:0] count_o,
    input logic             wrap_o,
    input logic             window_done_o,
    input logic             gate_val_o,
    input logic             pulse_busy_o
);
    // R2
    step_by_one_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(count_o) |-> (count_o == $past(count_o) + 1'b1));

    // R2
    hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        !tmr_on_i |=> $stable(count_o));

    // R7
    toggle_off_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !toggle_en_i |=> (!toggle_en_i || !gate_val_o));

    // R8
    timer_off_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (!tmr_on_i && toggle_en_i) |=> (!toggle_en_i || !gate_val_o));

    // R11
    wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
        wrap_o |-> (count_o == '0));

    // R9
    done_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
        window_done_o |-> !pulse_busy_o);
endmodule

bind gated_timer gated_timer_chk u_chk (.*);

// File: tb/tb_gated_timer.sv
module tb_gated_timer;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tmr_on_i = 0, gate_en_i = 0, gate_src_i = 0, gate_pin_i = 0;
    logic peer_wrap_i = 0, gate_inv_i = 0, toggle_en_i = 0;
    logic pulse_mode_i = 0, pulse_arm_i = 0;
    logic [15:0] count_o;
    logic wrap_o, window_done_o, gate_val_o, pulse_busy_o;

    int checks = 0;
    int errors = 0;
    int wraps_seen = 0;
    int dones_seen = 0;
    logic [15:0] snap;

    always #(CLK_PERIOD/2) clk = ~clk;

    gated_timer dut (.*);

    always @(negedge clk) begin
        if (!rst && wrap_o) wraps_seen++;
        if (!rst && window_done_o) dones_seen++;
    end

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual !== expected) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        tmr_on_i = 0; gate_en_i = 0; gate_src_i = 0; gate_pin_i = 0;
        peer_wrap_i = 0; gate_inv_i = 0; toggle_en_i = 0;
        pulse_mode_i = 0; pulse_arm_i = 0;
        rst = 1;
        tick(3);
        rst = 0;
        wraps_seen = 0;
        dones_seen = 0;
    endtask

    task automatic pin_pulse(input int hi, input int lo);
        gate_pin_i = 1; tick(hi);
        gate_pin_i = 0; tick(lo);
    endtask

    task automatic test_reset();
        do_reset();
        check("R1 count", count_o, 0);
        check("R1 flags", {wrap_o, window_done_o, gate_val_o, pulse_busy_o}, 0);
    endtask

    task automatic test_basic();
        do_reset();
        tmr_on_i = 1; gate_en_i = 1;
        tick(4);
        check("R2 idle gate holds", count_o, 0);
        pin_pulse(7, 5);
        check("R3 pin window length", count_o, 7);
        gate_en_i = 0; tick(12);
        check("R2 gate ignored", count_o, 19);
        tmr_on_i = 0; tick(10);
        check("R2 timer off holds", count_o, 19);
    endtask

    task automatic test_polarity();
        do_reset();
        gate_inv_i = 1; gate_pin_i = 1; tick(4);
        tmr_on_i = 1; gate_en_i = 1; tick(5);
        check("R4 inverted idle", count_o, 0);
        gate_pin_i = 0; tick(6);
        gate_pin_i = 1; tick(5);
        check("R4 inverted window", count_o, 6);
    endtask

    task automatic test_peer_source();
        do_reset();
        tmr_on_i = 1; gate_en_i = 1; gate_src_i = 1;
        gate_pin_i = 1; tick(4);
        check("R5 pin ignored with peer source", count_o, 0);
        gate_pin_i = 0;
        for (int i = 0; i < 3; i++) begin
            peer_wrap_i = 1; tick(1);
            peer_wrap_i = 0; tick(4);
        end
        check("R5 peer pulses counted", count_o, 3);
        do_reset();
        tmr_on_i = 1; gate_en_i = 1; gate_src_i = 1; toggle_en_i = 1;
        peer_wrap_i = 1; tick(1); peer_wrap_i = 0; tick(19);
        peer_wrap_i = 1; tick(1); peer_wrap_i = 0; tick(10);
        check("R6 peer toggle full period", count_o, 20);
    endtask

    task automatic test_toggle();
        do_reset();
        tmr_on_i = 1; gate_en_i = 1; toggle_en_i = 1;
        pin_pulse(3, 7);
        check("R6 gate high after first edge", gate_val_o, 1);
        pin_pulse(3, 7);
        tick(5);
        check("R6 pin toggle full period", count_o, 10);
        check("R6 gate low after second edge", gate_val_o, 0);
    endtask

    task automatic test_toggle_clear_mode();
        do_reset();
        tmr_on_i = 1; gate_en_i = 1; toggle_en_i = 1;
        pin_pulse(3, 7);
        toggle_en_i = 0; tick(2);
        toggle_en_i = 1; tick(1);
        check("R7 toggle flop cleared", gate_val_o, 0);
        snap = count_o;
        tick(6);
        check("R7 count holds after re-enable", count_o, snap);
    endtask

    task automatic test_toggle_clear_on();
        do_reset();
        tmr_on_i = 1; gate_en_i = 1; toggle_en_i = 1;
        pin_pulse(3, 7);
        check("R8 gate set before off", gate_val_o, 1);
        tmr_on_i = 0; tick(2);
        tmr_on_i = 1; tick(1);
        check("R8 toggle flop cleared by timer off", gate_val_o, 0);
        snap = count_o;
        tick(6);
        check("R8 count holds after timer on", count_o, snap);
    endtask

    task automatic test_one_shot();
        do_reset();
        tmr_on_i = 1; gate_en_i = 1; pulse_mode_i = 1;
        pulse_arm_i = 1; tick(1); pulse_arm_i = 0;
        check("R9 busy after arm", pulse_busy_o, 1);
        pin_pulse(5, 6);
        check("R9 one window counted", count_o, 5);
        check("R9 busy cleared", pulse_busy_o, 0);
        check("R9 done pulsed once", dones_seen, 1);
        pin_pulse(5, 6);
        check("R9 later window ignored", count_o, 5);
        check("R9 no second done", dones_seen, 1);
    endtask

    task automatic test_one_shot_toggle();
        do_reset();
        tmr_on_i = 1; gate_en_i = 1; pulse_mode_i = 1; toggle_en_i = 1;
        pulse_arm_i = 1; tick(1); pulse_arm_i = 0;
        pin_pulse(3, 9);
        pin_pulse(3, 9);
        pin_pulse(3, 9);
        pin_pulse(3, 9);
        check("R10 one full period", count_o, 12);
        check("R10 done once", dones_seen, 1);
    endtask

    task automatic test_wrap();
        do_reset();
        tmr_on_i = 1;
        tick(65535);
        check("R11 at top", count_o, 65535);
        check("R11 no early wrap", wraps_seen, 0);
        tick(1);
        tmr_on_i = 0;
        check("R11 wrapped to zero", count_o, 0);
        check("R11 wrap pulse", wrap_o, 1);
        tick(2);
        check("R11 single wrap pulse", wraps_seen, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 300000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        test_reset();
        test_basic();
        test_polarity();
        test_peer_source();
        test_toggle();
        test_toggle_clear_mode();
        test_toggle_clear_on();
        test_one_shot();
        test_one_shot_toggle();
        test_wrap();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule